// File: doc/BRIEF.md
# Double-Buffered DAC Channel Register Bank

This block holds the digital side of four converter channels. A host reaches it through a simple register port with an address, write data, a write enable, a read enable and registered read data. Each channel has a staging data register and a latch behind it. The latch is the code sent to the converter. A per-channel sync bit decides whether a data write goes straight to the latch or waits for a global load strobe. A load strobe moves only those synchronous channels that were written since the previous strobe. This avoids needless output steps on channels that did not change.

Each channel also has a clear bit and a programmable clear value. While the clear bit is set, the converter code is forced to the clear value. The staging register and the latch are not touched. When the clear bit drops, the code falls back to whatever the latch holds by then. A power-down register drives one flag per channel. The flags are all set after reset.

Register map: addresses 0 to 3 hold the channel data registers (channel number = address). Addresses 4 to 7 hold the channel clear values. Address 8 is the sync register, with bit n for channel n. Address 9 is the clear register and address 10 is the power-down register, both with the same bit layout. Address 11 is the config register; writing 1 to bit 11 issues a load. Addresses 12 to 15 are unmapped.

Top module: `dac_regbank`

## Requirements
- R1: After reset every converter code is 0 and every power-down flag is 1. Every data register, latch, clear value, sync bit and clear bit is 0.
- R2: A read (host_re) of data address n returns channel n's latch in host_rdata[9:0] on the following cycle, with the upper bits 0. It does not return the staging register.
- R3: A write to data address n while sync bit n is 0 updates the latch at that same clock edge. The write also clears the channel's pending state.
- R4: A write to data address n while sync bit n is 1 leaves the latch and the converter code unchanged, and marks the channel pending.
- R5: Writing a 1 to bit 11 of the config address (11) copies the data register into the latch for each channel that is both pending and synchronous. Channels that are not pending, or whose sync bit has since been cleared, keep their latch. The load clears every pending flag.
- R6: The load bit is a one-cycle strobe and is not stored. A read of the config address returns 0.
- R7: While clear bit n (bit n of address 9) is 1, converter code n equals clear value n (address 4+n), whatever the sync setting. Data writes and loads do not change that output, and the staging register is kept.
- R8: When clear bit n returns to 0, converter code n equals the current latch of channel n.
- R9: The clear values, sync register (address 8), clear register (address 9) and power-down register (address 10, bit n drives dac_pd[n]) read back what was written, in the low bits with the rest 0.
- R10: A read of any address from 12 to 15 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_we | input | 1 | Write enable, one write per cycle |
| host_re | input | 1 | Read enable |
| host_rdata | output | 16 | Read data, valid the cycle after host_re, 0 otherwise |
| dac_code | output | 40 | Four 10-bit converter codes, channel n in bits [10n+9:10n] |
| dac_pd | output | 4 | Per-channel power-down flags |

## Verification
Two functions can act on the same channel in one cycle: a clear override, and a latch update from an asynchronous write or a load strobe. The bench sets up this case on purpose. It sets a clear bit, then writes the channel's data and issues a load while the override holds. While the override is on, the converter code must stay equal to the clear value. Once the override is released, the code must equal the new latch value. The random phase mixes clear toggles with data writes and loads, and judges every code against the bench model after each access.

// File: rtl/dac_regbank_pkg.sv
// Package: dac_regbank_pkg
// Shared sizes and register-map helpers for the DAC register bank.
// Assumes a 4-bit address space; the map is derived from the channel count.
package dac_regbank_pkg;
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_DATA_W = 10;
    localparam int DEF_ADDR_W = 4;
    localparam int DEF_REG_W  = 16;
    localparam int LOAD_BIT   = 11;

    // Address of the first clear-value register.
    function automatic int clrv_base(input int nch);
        return nch;
    endfunction

    // Address of the sync register; clear, power-down and config follow it.
    function automatic int sync_addr(input int nch);
        return 2 * nch;
    endfunction
endpackage

// File: rtl/dac_channel.sv
// Module: dac_channel
// One converter channel: staging register, latch, pending flag, clear value
// and the clear override mux. Assumes that data_we, clrv_we and load are
// never high in the same cycle (a single host address is decoded per cycle).
module dac_channel #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              clrv_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sync_en,
    input  logic              clr_en,
    input  logic              load,
    output logic [DATA_W-1:0] latch_q,
    output logic [DATA_W-1:0] clrv_q,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] data_q;
    logic              pend_q;

    // Staging register and clear value, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            clrv_q <= '0;
        end else begin
            if (data_we) data_q <= wdata;
            if (clrv_we) clrv_q <= wdata;
        end
    end

    // Latch: immediate on asynchronous write, deferred to load when synchronous.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (data_we && !sync_en) begin
            latch_q <= wdata;
        end else if (load && pend_q && sync_en) begin
            latch_q <= data_q;
        end
    end

    // Pending flag: set by a synchronous write, cleared by a load or an asynchronous write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (data_we) begin
            pend_q <= sync_en;
        end else if (load) begin
            pend_q <= 1'b0;
        end
    end

    // Output mux: clear override bypasses the latch.
    always_comb begin
        code = clr_en ? clrv_q : latch_q;
    end
endmodule

// File: rtl/dac_ctrl_regs.sv
// Module: dac_ctrl_regs
// Sync, clear and power-down bit registers plus the load strobe decode.
// Assumes the config address directly follows the power-down address.
module dac_ctrl_regs #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 16,
    parameter int A_SYNC = 8,
    parameter int LOAD_B = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_CH-1:0] sync_q,
    output logic [NUM_CH-1:0] clr_q,
    output logic [NUM_CH-1:0] pd_q,
    output logic              load
);
    localparam logic [ADDR_W-1:0] A_S = ADDR_W'(A_SYNC);
    localparam logic [ADDR_W-1:0] A_C = ADDR_W'(A_SYNC + 1);
    localparam logic [ADDR_W-1:0] A_P = ADDR_W'(A_SYNC + 2);
    localparam logic [ADDR_W-1:0] A_G = ADDR_W'(A_SYNC + 3);

    // Bit registers for sync mode, clear override and power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            clr_q  <= '0;
            pd_q   <= '1;
        end else if (we) begin
            if (addr == A_S) sync_q <= wdata[NUM_CH-1:0];
            if (addr == A_C) clr_q  <= wdata[NUM_CH-1:0];
            if (addr == A_P) pd_q   <= wdata[NUM_CH-1:0];
        end
    end

    // Load strobe: lives only in the cycle of the config write.
    always_comb begin
        load = we && (addr == A_G) && wdata[LOAD_B];
    end
endmodule

// File: rtl/dac_read_mux.sv
// Module: dac_read_mux
// Registered read path. Data addresses return the latch; the config
// address and unmapped addresses return 0. Output is 0 when not reading.
module dac_read_mux #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 16,
    parameter int A_CLRV = 4,
    parameter int A_SYNC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     re,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CH*DATA_W-1:0] latch_flat,
    input  logic [NUM_CH*DATA_W-1:0] clrv_flat,
    input  logic [NUM_CH-1:0]        sync_q,
    input  logic [NUM_CH-1:0]        clr_q,
    input  logic [NUM_CH-1:0]        pd_q,
    output logic [REG_W-1:0]         rdata
);
    logic [REG_W-1:0] sel;

    // Address decode of the readable state.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i))
                sel = REG_W'(latch_flat[i*DATA_W +: DATA_W]);
            if (addr == ADDR_W'(A_CLRV + i))
                sel = REG_W'(clrv_flat[i*DATA_W +: DATA_W]);
        end
        if (addr == ADDR_W'(A_SYNC))     sel = REG_W'(sync_q);
        if (addr == ADDR_W'(A_SYNC + 1)) sel = REG_W'(clr_q);
        if (addr == ADDR_W'(A_SYNC + 2)) sel = REG_W'(pd_q);
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= re ? sel : '0;
    end
endmodule

// File: rtl/dac_regbank.sv
// Module: dac_regbank
// Top of the double-buffered DAC register bank: address decode, one
// dac_channel per channel, control bits and the read path.
// Assumes at most one host write per cycle and 2*NUM_CH+4 <= 2**ADDR_W.
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int REG_W  = DEF_REG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [REG_W-1:0]         host_wdata,
    input  logic                     host_we,
    input  logic                     host_re,
    output logic [REG_W-1:0]         host_rdata,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_pd
);
    localparam int A_CLRV = clrv_base(NUM_CH);
    localparam int A_SYNC = sync_addr(NUM_CH);

    logic [NUM_CH-1:0]        sync_q;
    logic [NUM_CH-1:0]        clr_q;
    logic                     load;
    logic [NUM_CH*DATA_W-1:0] latch_flat;
    logic [NUM_CH*DATA_W-1:0] clrv_flat;

    dac_ctrl_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .A_SYNC(A_SYNC), .LOAD_B(LOAD_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
        .wdata(host_wdata), .sync_q(sync_q), .clr_q(clr_q),
        .pd_q(dac_pd), .load(load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic data_we;
        logic clrv_we;
        // Per-channel write decode.
        always_comb begin
            data_we = host_we && (host_addr == ADDR_W'(g));
            clrv_we = host_we && (host_addr == ADDR_W'(A_CLRV + g));
        end

        dac_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .data_we(data_we), .clrv_we(clrv_we),
            .wdata(host_wdata[DATA_W-1:0]), .sync_en(sync_q[g]),
            .clr_en(clr_q[g]), .load(load),
            .latch_q(latch_flat[g*DATA_W +: DATA_W]),
            .clrv_q(clrv_flat[g*DATA_W +: DATA_W]),
            .code(dac_code[g*DATA_W +: DATA_W])
        );
    end

    dac_read_mux #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .A_CLRV(A_CLRV), .A_SYNC(A_SYNC)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .re(host_re), .addr(host_addr),
        .latch_flat(latch_flat), .clrv_flat(clrv_flat), .sync_q(sync_q),
        .clr_q(clr_q), .pd_q(dac_pd), .rdata(host_rdata)
    );
endmodule

// File: rtl/dac_regbank_chk.sv
// Module: dac_regbank_chk
// Assertion checker bound into dac_regbank. Watches the host port, the
// converter codes and the sync/clear bits.
module dac_regbank_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        host_addr,
    input logic [REG_W-1:0]         host_wdata,
    input logic                     host_we,
    input logic                     host_re,
    input logic [REG_W-1:0]         host_rdata,
    input logic [NUM_CH*DATA_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_pd,
    input logic [NUM_CH-1:0]        sync_q,
    input logic [NUM_CH-1:0]        clr_q
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(2 * NUM_CH + 3);
    localparam logic [ADDR_W-1:0] A_CLRR = ADDR_W'(2 * NUM_CH + 1);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&dac_pd) && (dac_code == '0));

    assert_cfg_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr == A_CFG) |=> host_rdata == '0);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr > A_CFG) |=> host_rdata == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        localparam logic [ADDR_W-1:0] A_D = ADDR_W'(g);
        localparam logic [ADDR_W-1:0] A_V = ADDR_W'(NUM_CH + g);

        assert_read_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (host_re && host_addr == A_D && !clr_q[g])
            |=> host_rdata == REG_W'($past(dac_code[g*DATA_W +: DATA_W])));

        assert_async_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && host_addr == A_D && !sync_q[g] && !clr_q[g])
            |=> dac_code[g*DATA_W +: DATA_W] == $past(host_wdata[DATA_W-1:0]));

        assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && host_addr == A_D && sync_q[g])
            |=> $stable(dac_code[g*DATA_W +: DATA_W]));

        assert_clear_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_q[g] && !(host_we && (host_addr == A_V || host_addr == A_CLRR)))
            |=> $stable(dac_code[g*DATA_W +: DATA_W]));
    end
endmodule

bind dac_regbank dac_regbank_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .dac_code(dac_code), .dac_pd(dac_pd), .sync_q(sync_q), .clr_q(clr_q)
);

// File: tb/sim_dac_regbank.sv
`timescale 1ns/1ps
module sim_dac_regbank;
    localparam int NCH = 4;
    localparam int DW  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [15:0] host_rdata;
    logic [NCH*DW-1:0] dac_code;
    logic [NCH-1:0]    dac_pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the register state
    logic [DW-1:0] m_data [NCH];
    logic [DW-1:0] m_latch[NCH];
    logic [DW-1:0] m_clrv [NCH];
    logic          m_pend [NCH];
    logic [NCH-1:0] m_sync, m_clr, m_pd;

    always #2.5 clk = ~clk;

    dac_regbank u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
        .dac_code(dac_code), .dac_pd(dac_pd)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_code(input int ch);
        return m_clr[ch] ? m_clrv[ch] : m_latch[ch];
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        if (a < 4)        return 16'(m_latch[a]);
        else if (a < 8)   return 16'(m_clrv[a-4]);
        else if (a == 8)  return 16'(m_sync);
        else if (a == 9)  return 16'(m_clr);
        else if (a == 10) return 16'(m_pd);
        return 16'h0;
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        if (a < 4)   return "R2";
        if (a < 11)  return "R9";
        if (a == 11) return "R6";
        return "R10";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_data[i] = '0; m_latch[i] = '0; m_clrv[i] = '0; m_pend[i] = 1'b0;
        end
        m_sync = '0; m_clr = '0; m_pd = '1;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [15:0] d);
        if (a < 4) begin
            m_data[a] = d[DW-1:0];
            if (!m_sync[a]) begin m_latch[a] = d[DW-1:0]; m_pend[a] = 1'b0; end
            else m_pend[a] = 1'b1;
        end else if (a < 8) m_clrv[a-4] = d[DW-1:0];
        else if (a == 8)  m_sync = d[NCH-1:0];
        else if (a == 9)  m_clr  = d[NCH-1:0];
        else if (a == 10) m_pd   = d[NCH-1:0];
        else if (a == 11 && d[11]) begin
            for (int i = 0; i < NCH; i++) begin
                if (m_pend[i] && m_sync[i]) m_latch[i] = m_data[i];
                m_pend[i] = 1'b0;
            end
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        chk(read_tag(a), 64'(host_rdata), 64'(exp_read(a)));
    endtask

    task automatic chk_code(input string req, input int ch);
        chk(req, 64'(dac_code[ch*DW +: DW]), 64'(exp_code(ch)));
    endtask

    task automatic chk_all_codes();
        for (int i = 0; i < NCH; i++) chk_code("R7/R8 code", i);
        chk("R9 pd", 64'(dac_pd), 64'(m_pd));
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 codes", 64'(dac_code), 64'h0);
        chk("R1 pd", 64'(dac_pd), 64'hF);
        rd(4'd0);
        rd(4'd10);
        // R3: asynchronous write shows immediately
        wr(4'd1, 16'h2A5);
        chk_code("R3", 1);
        rd(4'd1);
        // R4: synchronous write holds the latch
        wr(4'd8, 16'h4);
        wr(4'd2, 16'h155);
        chk_code("R4", 2);
        chk("R4 hold", 64'(dac_code[2*DW +: DW]), 64'h0);
        rd(4'd2);
        // R5: load moves the pending channel; R6 load bit reads 0
        wr(4'd11, 16'h0800);
        chk("R5 load", 64'(dac_code[2*DW +: DW]), 64'h155);
        rd(4'd11);
        // R5: pending channel whose sync bit was cleared is not reloaded
        wr(4'd8, 16'h8);
        wr(4'd3, 16'h3FF);
        wr(4'd8, 16'h0);
        wr(4'd11, 16'h0800);
        chk("R5 no reload", 64'(dac_code[3*DW +: DW]), 64'h0);
        // R7/R8: clear override collides with latch updates
        wr(4'd4, 16'h0CC);
        wr(4'd8, 16'h1);
        wr(4'd9, 16'h1);
        chk("R7 clear value", 64'(dac_code[DW-1:0]), 64'h0CC);
        wr(4'd0, 16'h111);
        wr(4'd11, 16'h0800);
        chk("R7 override kept", 64'(dac_code[DW-1:0]), 64'h0CC);
        rd(4'd0);
        wr(4'd9, 16'h0);
        chk("R8 back to latch", 64'(dac_code[DW-1:0]), 64'h111);
        // R7: async write under clear, then release
        wr(4'd8, 16'h0);
        wr(4'd9, 16'h2);
        wr(4'd1, 16'h077);
        chk("R7 async under clear", 64'(dac_code[DW +: DW]), 64'h0);
        wr(4'd9, 16'h0);
        chk("R8 async release", 64'(dac_code[DW +: DW]), 64'h077);
        // R9 / R10
        wr(4'd10, 16'h5);
        chk("R9 pd out", 64'(dac_pd), 64'h5);
        rd(4'd5);
        rd(4'd13);
        rd(4'd15);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  a;
            logic [15:0] d;
            d = 16'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                a = 4'($urandom_range(0, 15));
                rd(a);
            end else begin
                a = 4'($urandom_range(0, 11));
                if (a == 11 && $urandom_range(0, 1) == 1) d[11] = 1'b1;
                wr(a, d);
                chk_all_codes();
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule